// File: doc/BRIEF.md
# UART Transmitter with Break Sequencing

This block is the send half of an asynchronous serial port for a microcontroller-class peripheral. Software places characters into a small transmit queue through a four-offset register window. A serializer then shifts each character onto the serial line. Each character is framed with a start bit, five to eight data bits, an optional parity bit and one or two stop bits. The line control register sets the framing. It can also select odd or even parity, deliberately corrupt the parity bit, or hold the line in a break condition.

Bit timing comes from a single-cycle `baud_tick` strobe supplied from outside. Each strobe ends the current bit period and begins the next one. A break request does not cut into the bit in progress. At the next strobe the queue is emptied once and the line drops to a steady low. The line returns to idle on the first strobe after the request is withdrawn. One control bit re-points offsets 0 and 1 from the character port to the two bytes of the baud divisor. The divisor is presented on `baud_div` for an external rate generator.

Top module: `uart_tx_brk`

## Requirements
- R1: After reset `txd` is 1, `thr_empty` is 1, and the line control register and the divisor both read 0.
- R2: Offset 3 is the line control register; its bit 7 is the divisor switch. With bit 7 at 0, a write to offset 0 queues a character. With bit 7 at 1, offsets 0 and 1 write and read the low and high divisor bytes on `baud_div`, and nothing is queued. Offsets 0 and 1 read 0 while bit 7 is 0, and `baud_div` changes only on a register write.
- R3: A frame is a 0 start bit, then the data bits LSB first, then the parity bit if enabled, then the stop bits at 1. The number of data bits is 5 plus LCR[1:0]. LCR[2]=1 selects two stop bits. `txd` changes only on a cycle after `baud_tick`, one bit per strobe, and idles at 1.
- R4: With LCR[3]=1 a parity bit is sent. LCR[4]=0 makes data plus parity hold an odd count of ones; LCR[4]=1 makes it an even count.
- R5: With LCR[5]=1 and LCR[3]=1, the parity bit sent is the inverse of the R4 value. With LCR[3]=0, LCR[5] adds no bit.
- R6: Setting LCR[6] leaves `txd` unchanged until the next `baud_tick`. From that strobe on, `txd` stays 0 for as long as LCR[6] is set.
- R7: On the strobe that starts a break, the queue is emptied (`thr_empty` becomes 1). A write arriving in that same cycle is dropped. Neither the queued characters nor the remainder of the character being shifted are ever sent.
- R8: After LCR[6] is cleared, `txd` stays 0 until the next strobe, then returns to 1. Characters written during the break after `thr_empty` rose are sent after that.
- R9: The queue holds DEPTH characters in write order, and writes to a full queue are dropped. `thr_empty` is 1 exactly when the queue is empty, including when a write and a load fall on the same edge.
- R10: All eight bits of the line control register are writable and read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset for write and read |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, registered, one cycle after `reg_addr` |
| baud_tick | input | 1 | One-cycle bit-boundary strobe |
| baud_div | output | 16 | Divisor value for the external rate generator |
| txd | output | 1 | Serial output line |
| thr_empty | output | 1 | Transmit queue empty |

## Verification
Two pairs of events can land on the same clock edge. The first is the break-entry flush colliding with a character write. The bench raises `baud_tick` and `reg_we` in the same cycle while a break is pending. It then expects `thr_empty` to stay 1 and the line to carry no frame after recovery. The second is a queue push coinciding with the pop that loads the serializer. Here the bench writes on the loading strobe and expects `thr_empty` to stay 0 and both characters to come out back to back in order.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP1, S_STOP2, S_BREAK
  } tx_state_e;

  localparam int OFS_DLO = 0;
  localparam int OFS_DHI = 1;
  localparam int OFS_LCR = 3;

  // parity bit for the selected character length
  function automatic logic par_bit(logic [7:0] d, logic [1:0] len, logic even, logic force_err);
    logic [7:0] m;
    m = d & (8'hFF >> (2'd3 - len));
    return (^m) ^ ~even ^ force_err;
  endfunction

endpackage

// File: rtl/uart_tx_regs.sv
module uart_tx_regs #(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic [7:0]        lcr,
  output logic [15:0]       div_val,
  output logic              push
);
  import uart_tx_pkg::*;

  localparam logic [ADDR_W-1:0] A_DLO = ADDR_W'(OFS_DLO);
  localparam logic [ADDR_W-1:0] A_DHI = ADDR_W'(OFS_DHI);
  localparam logic [ADDR_W-1:0] A_LCR = ADDR_W'(OFS_LCR);

  logic dlab;
  assign dlab = lcr[7];
  assign push = reg_we && (reg_addr == A_DLO) && !dlab;

  always_ff @(posedge clk) begin
    if (rst) begin
      lcr     <= '0;
      div_val <= '0;
    end else if (reg_we) begin
      if (reg_addr == A_LCR) lcr <= reg_wdata;
      if (dlab && reg_addr == A_DLO) div_val[7:0]  <= reg_wdata;
      if (dlab && reg_addr == A_DHI) div_val[15:8] <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        A_DLO:   reg_rdata <= dlab ? div_val[7:0]  : 8'h00;
        A_DHI:   reg_rdata <= dlab ? div_val[15:8] : 8'h00;
        A_LCR:   reg_rdata <= lcr;
        default: reg_rdata <= 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  input  logic         flush,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [AW:0]   CAP  = (AW+1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt, cnt_next;
  logic          do_push, do_pop;

  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign dout    = mem[rp];

  always_comb begin
    cnt_next = cnt;
    if (flush) cnt_next = '0;
    else begin
      case ({do_push, do_pop})
        2'b10:   cnt_next = cnt + 1'b1;
        2'b01:   cnt_next = cnt - 1'b1;
        default: cnt_next = cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (do_push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      empty <= 1'b1;
      full  <= 1'b0;
    end else begin
      cnt   <= cnt_next;
      empty <= (cnt_next == '0);
      full  <= (cnt_next == CAP);
    end
  end
endmodule

// File: rtl/uart_tx_ser.sv
module uart_tx_ser (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       brk_req,
  input  logic       pen,
  input  logic       even_par,
  input  logic       force_err,
  input  logic       stop2,
  input  logic [1:0] len,
  input  logic       f_empty,
  input  logic [7:0] f_data,
  output logic       f_pop,
  output logic       f_flush,
  output logic       txd,
  output logic       in_break,
  output logic       tx_idle
);
  import uart_tx_pkg::*;

  tx_state_e  state;
  logic [7:0] shreg;
  logic [3:0] bitcnt, nbits;
  logic [1:0] len_q;
  logic       pen_q, par_q, stop2_q;
  logic       brk_entry, load_slot;

  assign nbits     = 4'd5 + {2'b00, len_q};
  assign brk_entry = tick && brk_req && (state != S_BREAK);
  assign load_slot = (state == S_IDLE) || (state == S_STOP2) ||
                     (state == S_STOP1 && !stop2_q);
  assign f_flush   = brk_entry;
  assign f_pop     = tick && !brk_entry && load_slot && !f_empty;
  assign in_break  = (state == S_BREAK);
  assign tx_idle   = (state == S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      txd     <= 1'b1;
      shreg   <= '0;
      bitcnt  <= '0;
      len_q   <= '0;
      pen_q   <= 1'b0;
      par_q   <= 1'b0;
      stop2_q <= 1'b0;
    end else if (tick) begin
      if (brk_entry) begin
        state <= S_BREAK;
        txd   <= 1'b0;
      end else if (state == S_BREAK) begin
        if (!brk_req) begin
          state <= S_IDLE;
          txd   <= 1'b1;
        end
      end else if (load_slot) begin
        if (!f_empty) begin
          shreg   <= f_data;
          len_q   <= len;
          pen_q   <= pen;
          stop2_q <= stop2;
          par_q   <= par_bit(f_data, len, even_par, force_err);
          txd     <= 1'b0;
          state   <= S_START;
        end else begin
          txd   <= 1'b1;
          state <= S_IDLE;
        end
      end else begin
        case (state)
          S_START: begin
            txd    <= shreg[0];
            shreg  <= shreg >> 1;
            bitcnt <= 4'd1;
            state  <= S_DATA;
          end
          S_DATA: begin
            if (bitcnt == nbits) begin
              if (pen_q) begin
                txd   <= par_q;
                state <= S_PAR;
              end else begin
                txd   <= 1'b1;
                state <= S_STOP1;
              end
            end else begin
              txd    <= shreg[0];
              shreg  <= shreg >> 1;
              bitcnt <= bitcnt + 1'b1;
            end
          end
          S_PAR: begin
            txd   <= 1'b1;
            state <= S_STOP1;
          end
          S_STOP1: begin
            txd   <= 1'b1;
            state <= S_STOP2;
          end
          default: begin
            txd   <= 1'b1;
            state <= S_IDLE;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_tx_brk.sv
module uart_tx_brk #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              baud_tick,
  output logic [15:0]       baud_div,
  output logic              txd,
  output logic              thr_empty
);
  logic [7:0] lcr;
  logic       push, f_pop, f_flush, f_full;
  logic [7:0] f_data;
  logic       ser_in_break, ser_idle;

  uart_tx_regs #(.ADDR_W(ADDR_W)) i_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lcr(lcr),
    .div_val(baud_div), .push(push)
  );

  uart_tx_fifo #(.DEPTH(DEPTH), .W(8)) i_fifo (
    .clk(clk), .rst(rst), .push(push), .din(reg_wdata), .pop(f_pop),
    .flush(f_flush), .dout(f_data), .empty(thr_empty), .full(f_full)
  );

  uart_tx_ser i_ser (
    .clk(clk), .rst(rst), .tick(baud_tick), .brk_req(lcr[6]),
    .pen(lcr[3]), .even_par(lcr[4]), .force_err(lcr[5]), .stop2(lcr[2]),
    .len(lcr[1:0]), .f_empty(thr_empty), .f_data(f_data), .f_pop(f_pop),
    .f_flush(f_flush), .txd(txd), .in_break(ser_in_break), .tx_idle(ser_idle)
  );
endmodule

// File: rtl/uart_tx_brk_chk.sv
module uart_tx_brk_chk (
  input logic        clk,
  input logic        rst,
  input logic        reg_we,
  input logic        baud_tick,
  input logic [15:0] baud_div,
  input logic        txd,
  input logic        thr_empty,
  input logic        in_break,
  input logic        tx_idle
);
  a_r1_reset_state: assert property (@(posedge clk) rst |=> (txd && thr_empty));

  a_r3_txd_on_tick: assert property (@(posedge clk) disable iff (rst)
    !baud_tick |=> $stable(txd));

  a_r3_idle_high: assert property (@(posedge clk) disable iff (rst)
    tx_idle |-> txd);

  a_r6_break_low: assert property (@(posedge clk) disable iff (rst)
    in_break |-> !txd);

  a_r7_flush_empty: assert property (@(posedge clk) disable iff (rst)
    $rose(in_break) |-> thr_empty);

  a_r9_no_phantom: assert property (@(posedge clk) disable iff (rst)
    (thr_empty && !reg_we) |=> thr_empty);

  a_r2_div_hold: assert property (@(posedge clk) disable iff (rst)
    !reg_we |=> $stable(baud_div));
endmodule

bind uart_tx_brk uart_tx_brk_chk i_chk (
  .clk(clk), .rst(rst), .reg_we(reg_we), .baud_tick(baud_tick),
  .baud_div(baud_div), .txd(txd), .thr_empty(thr_empty),
  .in_break(ser_in_break), .tx_idle(ser_idle)
);

// File: tb/test_uart_tx_brk.sv
module test_uart_tx_brk;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        baud_tick = 1'b0;
  logic [15:0] baud_div;
  logic        txd, thr_empty;

  int checks = 0;
  int errs   = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  uart_tx_brk #(.DEPTH(DEPTH), .ADDR_W(2)) i_uart_tx_brk (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .baud_tick(baud_tick),
    .baud_div(baud_div), .txd(txd), .thr_empty(thr_empty)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic tick();
    @(negedge clk);
    baud_tick = 1'b1;
    @(negedge clk);
    baud_tick = 1'b0;
  endtask

  // write a character on the same edge as a strobe
  task automatic tick_wr(logic [7:0] d);
    @(negedge clk);
    baud_tick = 1'b1; reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = d;
    @(negedge clk);
    baud_tick = 1'b0; reg_we = 1'b0;
  endtask

  // expected frame built from the requirements
  function automatic int build(logic [7:0] d, logic [7:0] l, output logic [11:0] b);
    int n, nb, ones;
    logic p;
    b = '1; n = 0; ones = 0;
    nb = 5 + int'(l[1:0]);
    b[n++] = 1'b0;
    for (int i = 0; i < nb; i++) begin
      b[n++] = d[i];
      ones += int'(d[i]);
    end
    if (l[3]) begin
      p = l[4] ? ones[0] : ~ones[0];
      if (l[5]) p = ~p;
      b[n++] = p;
    end
    b[n++] = 1'b1;
    if (l[2]) b[n++] = 1'b1;
    return n;
  endfunction

  task automatic frame_chk(logic [7:0] d, logic [7:0] l, string req);
    logic [11:0] b;
    int n;
    n = build(d, l, b);
    for (int i = 0; i < n; i++) begin
      tick();
      chk(req, int'(txd), int'(b[i]));
    end
  endtask

  task automatic idle_chk(int n, string req);
    for (int i = 0; i < n; i++) begin
      tick();
      chk(req, int'(txd), 1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] l;
    logic [7:0] d;
    logic       prev;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 txd", int'(txd), 1);
    chk("R1 thr_empty", int'(thr_empty), 1);
    rd(2'd3, v); chk("R1 lcr", int'(v), 0);
    chk("R1 div", int'(baud_div), 0);

    // R2 aliasing
    wr(2'd3, 8'h80);
    wr(2'd0, 8'h34);
    wr(2'd1, 8'h12);
    chk("R2 div out", int'(baud_div), 16'h1234);
    chk("R2 no queue", int'(thr_empty), 1);
    rd(2'd0, v); chk("R2 div lo", int'(v), 8'h34);
    rd(2'd1, v); chk("R2 div hi", int'(v), 8'h12);
    wr(2'd3, 8'h03);
    rd(2'd0, v); chk("R2 data ofs reads 0", int'(v), 0);
    chk("R2 div kept", int'(baud_div), 16'h1234);
    idle_chk(2, "R2 nothing sent");

    // R10 all lcr bits
    wr(2'd3, 8'hBC); rd(2'd3, v); chk("R10 lcr BC", int'(v), 8'hBC);
    wr(2'd3, 8'h43); rd(2'd3, v); chk("R10 lcr 43", int'(v), 8'h43);
    tick(); // enters break on empty queue
    wr(2'd3, 8'h03); tick();
    chk("R8 recovered", int'(txd), 1);

    // R3 basic frames
    wr(2'd0, 8'hA5); frame_chk(8'hA5, 8'h03, "R3 8N1"); idle_chk(1, "R3 idle");
    wr(2'd3, 8'h00); wr(2'd0, 8'hFF); frame_chk(8'hFF, 8'h00, "R3 5 bits"); idle_chk(1, "R3 idle");
    wr(2'd3, 8'h05); wr(2'd0, 8'h5A); frame_chk(8'h5A, 8'h05, "R3 two stop"); idle_chk(1, "R3 idle");

    // R4 parity type
    wr(2'd3, 8'h1B); wr(2'd0, 8'h07); frame_chk(8'h07, 8'h1B, "R4 even"); idle_chk(1, "R4 idle");
    wr(2'd3, 8'h0B); wr(2'd0, 8'h07); frame_chk(8'h07, 8'h0B, "R4 odd"); idle_chk(1, "R4 idle");
    wr(2'd3, 8'h09); wr(2'd0, 8'h3C); frame_chk(8'h3C, 8'h09, "R4 odd 6 bits"); idle_chk(1, "R4 idle");

    // R5 forced parity error
    wr(2'd3, 8'h2B); wr(2'd0, 8'h07); frame_chk(8'h07, 8'h2B, "R5 forced"); idle_chk(1, "R5 idle");
    wr(2'd3, 8'h23); wr(2'd0, 8'h07); frame_chk(8'h07, 8'h23, "R5 no pen"); idle_chk(1, "R5 idle");

    // random framing
    for (int k = 0; k < 40; k++) begin
      l = 8'($urandom()) & 8'h3F;
      d = 8'($urandom());
      wr(2'd3, l); wr(2'd0, d);
      frame_chk(d, l, "R3 random");
      idle_chk(1, "R3 random idle");
    end

    // R9 depth, order and drop when full
    wr(2'd3, 8'h03);
    for (int i = 0; i <= DEPTH; i++) wr(2'd0, 8'(i * 29 + 3));
    chk("R9 not empty", int'(thr_empty), 0);
    for (int i = 0; i < DEPTH; i++) frame_chk(8'(i * 29 + 3), 8'h03, "R9 order");
    idle_chk(1, "R9 ninth dropped");
    chk("R9 empty after", int'(thr_empty), 1);

    // R9 push on the loading edge
    wr(2'd0, 8'h6E);
    tick_wr(8'h91);
    chk("R9 push+pop start", int'(txd), 0);
    chk("R9 push+pop nonempty", int'(thr_empty), 0);
    begin
      logic [11:0] b;
      int n;
      n = build(8'h6E, 8'h03, b);
      for (int i = 1; i < n; i++) begin
        tick();
        chk("R9 first frame", int'(txd), int'(b[i]));
      end
    end
    frame_chk(8'h91, 8'h03, "R9 second frame");
    idle_chk(1, "R9 idle");

    // R6 / R7 / R8 break mid-frame
    wr(2'd0, 8'hA5); wr(2'd0, 8'h3C);
    tick(); tick(); tick();
    prev = txd;
    wr(2'd3, 8'h43);
    chk("R6 not immediate", int'(txd), int'(prev));
    chk("R7 queue before boundary", int'(thr_empty), 0);
    tick();
    chk("R6 low at boundary", int'(txd), 0);
    chk("R7 flushed", int'(thr_empty), 1);
    for (int i = 0; i < 3; i++) begin tick(); chk("R6 held low", int'(txd), 0); end
    wr(2'd0, 8'h5A);
    chk("R8 write kept", int'(thr_empty), 0);
    tick(); chk("R6 still low", int'(txd), 0);
    wr(2'd3, 8'h03);
    chk("R8 not immediate", int'(txd), 0);
    tick(); chk("R8 idle after", int'(txd), 1);
    frame_chk(8'h5A, 8'h03, "R8 sent after");
    idle_chk(12, "R7 flushed data never sent");

    // R7 write colliding with flush
    wr(2'd3, 8'h43);
    tick_wr(8'h11);
    chk("R7 collide low", int'(txd), 0);
    chk("R7 collide dropped", int'(thr_empty), 1);
    wr(2'd3, 8'h03);
    tick(); chk("R8 idle", int'(txd), 1);
    idle_chk(12, "R7 dropped write not sent");

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule